// File: doc/BRIEF.md
# Self-correcting Johnson decade counter

This block is a synchronous model of a five-stage twisted-ring counter that steps through ten states and presents them as ten one-hot decoded outputs, plus an active-low carry that is low for the upper half of the count. It has two count inputs of opposite edge polarity: a rising edge on one counts only while the other is low, and a falling edge on the other counts only while the first is high. Both count inputs are brought onto the system clock through a two-flop synchronizer, and edges are found by comparing successive synchronized samples, so a count reaches the outputs three clock edges after the input changes.

A level-sensitive clear forces state 0 and wins over any count in the same cycle. The feedback path of one interior stage carries correction logic, so that a ring holding a pattern outside the ten legal ones returns to the legal cycle within eleven counts. A test-only preload port writes any five-bit pattern into the ring so that recovery can be exercised from every starting point. The decoded outputs and the carry are registered from the ring's next value, so they change on the same edge as the ring.

Top module: `decade_ring_counter`

## Requirements
- R1: Legal ring patterns (bit 4 down to bit 0) for states 0 to 9 are 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000; in state k exactly dec_out[k] is high, and any other pattern drives two or more dec_out bits high.
- R2: A low-to-high change of cnt_rise while cnt_fall is low advances the state by one; the new state appears on the outputs at the third rising clk edge after the input change.
- R3: A high-to-low change of cnt_fall while cnt_rise is high advances the state by one, with the same latency as R2.
- R4: The state holds for a falling cnt_rise, a rising cnt_fall, a rising cnt_rise while cnt_fall is high, a falling cnt_fall while cnt_rise is low, and steady inputs.
- R5: While clr is high, the state is 0 (dec_out = 0x001, carry_n = 1) from the next clk edge on, whatever the count inputs do.
- R6: carry_n is 0 in states 5 to 9 and 1 in states 0 to 4.
- R7: The state after 9 is 0, so carry_n rises on that wrap.
- R8: When clr and a qualified count fall in the same cycle, clear wins and the count is not applied later.
- R9: load_en high at a clk edge writes load_val into the ring (bit 4 is the most significant stage), taking priority over a count but not over clr.
- R10: From any of the 32 patterns the outputs are one-hot again after at most 11 counts, and from a legal pattern each count moves to the next legal state.
- R11: rst high at a clk edge gives state 0 and clears the synchronizer history; it overrides every other input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Level clear to state 0, beats counts and preload |
| cnt_rise | input | 1 | Count input, rising edge counts while cnt_fall is low |
| cnt_fall | input | 1 | Count input, falling edge counts while cnt_rise is high |
| load_en | input | 1 | Test-only preload strobe |
| load_val | input | 5 | Test-only ring pattern to preload |
| dec_out | output | 10 | One-hot decoded state, bit k for state k |
| carry_n | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
The functions that can meet in one cycle are a qualified count and the clear. The bench raises cnt_rise, waits exactly until the synchronized edge is being qualified, and raises clr for that single cycle, so that both act on the same clk edge. It judges the outcome as state 0 right after, and still state 0 several cycles later, which shows that the count was neither applied first nor deferred.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  // What the ring does at the next clock edge.
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_STEP  = 2'd1,
    UPD_CLEAR = 2'd2,
    UPD_LOAD  = 2'd3
  } upd_e;
endpackage

// File: rtl/jdc_edge_qual.sv
module jdc_edge_qual #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_in,
  input  logic fall_in,
  output logic step
);
  localparam int MSB = SYNC_DEPTH - 1;

  logic [MSB:0] rise_sync, fall_sync;
  logic         rise_prev, fall_prev;
  logic         rise_lvl, fall_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_sync <= '0;
      fall_sync <= '0;
      rise_prev <= 1'b0;
      fall_prev <= 1'b0;
    end else begin
      rise_sync <= {rise_sync[MSB-1:0], rise_in};
      fall_sync <= {fall_sync[MSB-1:0], fall_in};
      rise_prev <= rise_sync[MSB];
      fall_prev <= fall_sync[MSB];
    end
  end

  assign rise_lvl = rise_sync[MSB];
  assign fall_lvl = fall_sync[MSB];

  // Each edge is gated by the current level of the other input.
  assign step = (rise_lvl & ~rise_prev & ~fall_lvl) |
                (~fall_lvl & fall_prev & rise_lvl);

  // R4: with both synchronized inputs unchanged there is no count.
  a_r4_quiet_no_step: assert property (@(posedge clk) disable iff (rst)
    (rise_lvl == rise_prev && fall_lvl == fall_prev) |-> !step);
endmodule

// File: rtl/jdc_ring_core.sv
module jdc_ring_core
  import jdc_pkg::*;
#(
  parameter int STAGES    = 5,
  parameter int FIX_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  upd_e              upd,
  input  logic [STAGES-1:0] load_val,
  output logic [STAGES-1:0] ring_q,
  output logic [STAGES-1:0] ring_nxt
);
  logic [STAGES-1:0] shift_nxt;

  // Twisted ring: stage 0 takes the inverted top stage. One interior stage
  // refuses to pass a lone one, which breaks up any second run of ones.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_twist
      assign shift_nxt[k] = ~ring_q[STAGES-1];
    end else if (k == FIX_STAGE) begin : g_fix
      assign shift_nxt[k] = ring_q[k-1] & (ring_q[k-2] | ring_q[k]);
    end else begin : g_plain
      assign shift_nxt[k] = ring_q[k-1];
    end
  end

  always_comb begin
    case (upd)
      UPD_CLEAR: ring_nxt = '0;
      UPD_LOAD:  ring_nxt = load_val;
      UPD_STEP:  ring_nxt = shift_nxt;
      default:   ring_nxt = ring_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= '0;
    else     ring_q <= ring_nxt;
  end

  // R11: reset leaves the ring empty.
  a_r11_reset_empty: assert property (@(posedge clk)
    rst |=> ring_q == '0);
endmodule

// File: rtl/jdc_decoder.sv
module jdc_decoder #(
  parameter int STAGES = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [STAGES-1:0]     ring_nxt,
  output logic [2*STAGES-1:0]   dec_q,
  output logic                  carry_nq
);
  localparam int COUNT = 2 * STAGES;

  logic [COUNT-1:0] dec_d;

  // Each state is marked by one boundary between adjacent ring bits.
  for (genvar k = 0; k < COUNT; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign dec_d[k] = ~ring_nxt[STAGES-1] & ~ring_nxt[0];
    end else if (k < STAGES) begin : g_fill
      assign dec_d[k] = ring_nxt[k-1] & ~ring_nxt[k];
    end else if (k == STAGES) begin : g_full
      assign dec_d[k] = ring_nxt[STAGES-1] & ring_nxt[0];
    end else begin : g_drain
      assign dec_d[k] = ~ring_nxt[k-STAGES-1] & ring_nxt[k-STAGES];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q    <= COUNT'(1);
      carry_nq <= 1'b1;
    end else begin
      dec_q    <= dec_d;
      carry_nq <= ~ring_nxt[STAGES-1];
    end
  end

  // R6: carry agrees with the decoded half whenever the state is legal.
  a_r6_carry_half: assert property (@(posedge clk) disable iff (rst)
    $onehot(dec_q) |-> carry_nq == ~|dec_q[COUNT-1:STAGES]);
endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter
  import jdc_pkg::*;
#(
  parameter int STAGES     = 5,
  parameter int SYNC_DEPTH = 2,
  parameter int FIX_STAGE  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                cnt_rise,
  input  logic                cnt_fall,
  input  logic                load_en,
  input  logic [STAGES-1:0]   load_val,
  output logic [2*STAGES-1:0] dec_out,
  output logic                carry_n
);
  localparam int COUNT = 2 * STAGES;

  logic              step;
  upd_e              upd;
  logic [STAGES-1:0] ring_q, ring_nxt;

  jdc_edge_qual #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
    .clk(clk), .rst(rst), .rise_in(cnt_rise), .fall_in(cnt_fall), .step(step)
  );

  // Clear beats preload, preload beats a count.
  always_comb begin
    if (clr)          upd = UPD_CLEAR;
    else if (load_en) upd = UPD_LOAD;
    else if (step)    upd = UPD_STEP;
    else              upd = UPD_HOLD;
  end

  jdc_ring_core #(.STAGES(STAGES), .FIX_STAGE(FIX_STAGE)) u_core (
    .clk(clk), .rst(rst), .upd(upd), .load_val(load_val),
    .ring_q(ring_q), .ring_nxt(ring_nxt)
  );

  jdc_decoder #(.STAGES(STAGES)) u_dec (
    .clk(clk), .rst(rst), .ring_nxt(ring_nxt),
    .dec_q(dec_out), .carry_nq(carry_n)
  );

  // R2, R3, R7: a count moves the one-hot output up by one, 9 wrapping to 0.
  a_r2_step_rotates: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !load_en && $onehot(dec_out)) |=>
      dec_out == {$past(dec_out[COUNT-2:0]), $past(dec_out[COUNT-1])});

  // R4: without count, clear or preload nothing moves.
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr && !load_en) |=> ($stable(dec_out) && $stable(carry_n)));

  // R5, R8: clear gives state 0 even against a count.
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dec_out == COUNT'(1) && carry_n));

  a_r8_clear_beats_step: assert property (@(posedge clk) disable iff (rst)
    (clr && step) |=> ring_q == '0);

  // R10: once legal, counting keeps it legal.
  a_r10_legal_kept: assert property (@(posedge clk) disable iff (rst)
    (!load_en && $onehot(dec_out)) |=> $onehot(dec_out));
endmodule

// File: tb/sim_decade_ring_counter.sv
module sim_decade_ring_counter;
  localparam int STAGES = 5;
  localparam int COUNT  = 2 * STAGES;

  logic clk = 1'b0;
  logic rst, clr, cnt_rise, cnt_fall, load_en;
  logic [STAGES-1:0] load_val;
  logic [COUNT-1:0]  dec_out;
  logic              carry_n;

  int checks = 0;
  int errors = 0;
  int exp_idx = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  decade_ring_counter u0 (
    .clk(clk), .rst(rst), .clr(clr), .cnt_rise(cnt_rise), .cnt_fall(cnt_fall),
    .load_en(load_en), .load_val(load_val), .dec_out(dec_out), .carry_n(carry_n)
  );

  task automatic step_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idx(input int k, input string tag);
    logic [COUNT-1:0] e;
    e = COUNT'(1) << k;
    chk(dec_out == e, tag, "dec_out", 32'(dec_out), 32'(e));
    chk(carry_n == (k < 5), tag, "carry_n", 32'(carry_n), 32'(k < 5));
  endtask

  // Legal index of a pattern per R1, or -1.
  function automatic int leg_idx(input logic [STAGES-1:0] p);
    for (int k = 0; k < COUNT; k++) begin
      logic [STAGES-1:0] q;
      if (k <= STAGES) q = STAGES'(32'h1f >> (STAGES - k));
      else             q = STAGES'(32'h1f << (k - STAGES));
      if (q == p) return k;
    end
    return -1;
  endfunction

  task automatic pulse_rise(input string tag);
    cnt_rise = 1'b1; step_n(4);
    exp_idx = (exp_idx + 1) % COUNT;
    chk_idx(exp_idx, tag);
    cnt_rise = 1'b0; step_n(4);
    chk_idx(exp_idx, "R4 falling cnt_rise");
  endtask

  task automatic t_reset;
    rst = 1'b1; clr = 0; cnt_rise = 0; cnt_fall = 0; load_en = 0; load_val = '0;
    step_n(3);
    chk_idx(0, "R11 during reset");
    rst = 1'b0; step_n(2);
    exp_idx = 0;
    chk_idx(0, "R11 after reset");
  endtask

  task automatic t_rise_count;
    for (int i = 0; i < 3; i++) pulse_rise("R2 rise count");
  endtask

  task automatic t_fall_count;
    cnt_fall = 1'b1; step_n(4); chk_idx(exp_idx, "R4 rising cnt_fall");
    cnt_rise = 1'b1; step_n(4); chk_idx(exp_idx, "R4 rise while cnt_fall high");
    for (int i = 0; i < 2; i++) begin
      cnt_fall = 1'b0; step_n(4);
      exp_idx = (exp_idx + 1) % COUNT;
      chk_idx(exp_idx, "R3 fall count");
      cnt_fall = 1'b1; step_n(4); chk_idx(exp_idx, "R4 rising cnt_fall");
    end
    cnt_rise = 1'b0; step_n(4); chk_idx(exp_idx, "R4 falling cnt_rise");
    cnt_fall = 1'b0; step_n(4); chk_idx(exp_idx, "R4 fall while cnt_rise low");
  endtask

  task automatic t_wrap;
    while (exp_idx != 9) pulse_rise("R6 carry per state");
    chk(carry_n == 1'b0, "R6", "carry_n in state 9", 32'(carry_n), 0);
    pulse_rise("R7 wrap 9 to 0");
  endtask

  task automatic t_clear;
    while (exp_idx != 7) pulse_rise("R2 to state 7");
    clr = 1'b1; step_n(1);
    exp_idx = 0;
    chk_idx(0, "R5 clear");
    cnt_rise = 1'b1; step_n(4); chk_idx(0, "R5 count blocked by clear");
    cnt_rise = 1'b0; step_n(4);
    clr = 1'b0; step_n(4);
    chk_idx(0, "R5 after clear release");
  endtask

  task automatic t_collide;
    pulse_rise("R2 before collision");
    pulse_rise("R2 before collision");
    cnt_rise = 1'b1;
    step_n(2);
    clr = 1'b1; step_n(1);
    clr = 1'b0;
    exp_idx = 0;
    chk_idx(0, "R8 clear with count");
    step_n(5);
    chk_idx(0, "R8 count not deferred");
    cnt_rise = 1'b0; step_n(4);
  endtask

  task automatic t_preload;
    for (int p = 0; p < 32; p++) begin
      int k;
      int n;
      k = leg_idx(STAGES'(p));
      load_val = STAGES'(p); load_en = 1'b1; step_n(1);
      load_en = 1'b0;
      if (k >= 0) begin
        exp_idx = k;
        chk_idx(k, "R9 preload legal");
        pulse_rise("R10 legal step");
      end else begin
        chk($countones(dec_out) >= 2, "R1", "illegal decode count",
            32'($countones(dec_out)), 2);
        n = 0;
        while (!$onehot(dec_out) && n < 12) begin
          cnt_rise = 1'b1; step_n(4);
          cnt_rise = 1'b0; step_n(4);
          n++;
        end
        chk(n <= 11, "R10", "counts to recover", 32'(n), 11);
      end
    end
  endtask

  initial begin
    t_reset();
    t_rise_count();
    t_fall_count();
    t_wrap();
    t_clear();
    t_collide();
    t_preload();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule